// File: doc/BRIEF.md
# Byte-wide Program Memory Read Unit

This block lets a small processor core fetch constant data out of a 16-bit-wide program memory one byte at a time. It keeps a 22-bit byte pointer, which software loads through three byte-wide registers called low, high and upper. It also keeps an 8-bit result latch. A read command names one of four pointer-update modes. The block then requests the memory word that holds the addressed byte, places the selected half of that word into the latch and moves the pointer as the mode requires.

The pointer splits into two parts. The top bit chooses between the main program space and the configuration space. The remaining 21 bits address bytes within that space. Automatic increment and decrement act on the 21 low bits only, so a pointer that steps past either end wraps within its own space and never crosses into the other one. The memory side uses a plain request/valid handshake with a wait of any length. Status is given by a busy level and a done pulse.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, all three pointer registers, the latch, `busy`, `done` and `memReq` read zero.
- R2: A pointer register write takes effect at the next clock edge. `regSel` code 0 selects low (pointer bits 7:0), 1 selects high (bits 15:8) and 2 selects upper (bits 21:16). Code 3 changes nothing. Upper bits 7:6 always read back as zero, whatever value was written.
- R3: Mode 00 reads the byte at the pointer and leaves the pointer unchanged.
- R4: Mode 01 reads the byte at the pointer and then adds one to the pointer.
- R5: Mode 10 reads the byte at the pointer and then subtracts one from the pointer.
- R6: Mode 11 adds one to the pointer first and then reads. Both the word address and the byte choice come from the incremented value, and the pointer keeps that value.
- R7: `memAddr` equals pointer bits 21:1. An even pointer loads `memData[7:0]` into the latch; an odd pointer loads `memData[15:8]`.
- R8: Increment and decrement wrap modulo 2^21 in bits 20:0. Neither one changes bit 21.
- R9: From the cycle after an accepted command until the cycle in which `memValid` is seen, `busy` and `memReq` are high and `memAddr` holds steady. In the cycle after `memValid`, `done` is high for exactly one cycle, `busy` is low, and the latch and pointer show their new values.
- R10: A read command that arrives while `busy` is high is ignored. It changes neither the address issued nor the resulting latch or pointer.
- R11: If a software register write lands on the same edge as a read completing, the written byte takes the software value. The other pointer bytes take the automatic update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Pointer register write strobe |
| regSel | input | 2 | Pointer byte select (0 low, 1 high, 2 upper) |
| regWrData | input | 8 | Pointer byte write value |
| ptrLow | output | 8 | Pointer bits 7:0 |
| ptrHigh | output | 8 | Pointer bits 15:8 |
| ptrUpper | output | 8 | Pointer bits 21:16, bits 7:6 zero |
| latchOut | output | 8 | Result latch |
| rdStart | input | 1 | Read command strobe |
| rdMode | input | 2 | Pointer-update mode for the read |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle read completion pulse |
| memReq | output | 1 | Memory request |
| memAddr | output | 21 | Word address to program memory |
| memValid | input | 1 | Memory data valid |
| memData | input | 16 | Memory word |

## Verification
The bench builds the block with the default 22-bit pointer. At this width, pointers such as 0x3FFFFF, 0x200000 and 0x1FFFFF can be written directly. That puts both wrap directions and the configuration-space boundary within reach of a few directed reads. Memory latency is set from zero to several cycles so that both the back-to-back completion and the held-request path are exercised. The software-write collision is checked on a read whose increment carries into the high byte.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP    = 2'b00,
    MODE_POSTINC = 2'b01,
    MODE_POSTDEC = 2'b10,
    MODE_PREINC  = 2'b11
  } rdMode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2
  } regSel_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrb_t;
endpackage

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdStart,
  input  logic      memValid,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      memReq
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e stateQ;
  logic   doneQ;

  always_comb begin
    strb.capture = (stateQ == ST_IDLE) && rdStart;
    strb.commit  = (stateQ == ST_WAIT) && memValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.commit;
      if (strb.capture)     stateQ <= ST_WAIT;
      else if (strb.commit) stateQ <= ST_IDLE;
    end
  end

  assign busy   = (stateQ == ST_WAIT);
  assign memReq = busy;
  assign done   = doneQ;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq);
  p_done_after_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid) |=> (done && !busy));
endmodule

// File: rtl/tblrd_dpath.sv
module tblrd_dpath
  import tblrd_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int WORD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [1:0]         rdMode,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [7:0]         regWrData,
  input  logic [WORD_W-1:0]  memData,
  output logic [7:0]         ptrLow,
  output logic [7:0]         ptrHigh,
  output logic [7:0]         ptrUpper,
  output logic [7:0]         latchOut,
  output logic [PTR_W-2:0]   memAddr
);
  localparam int REG_W  = 24;
  localparam int LOW_W  = PTR_W - 1;
  localparam int HALF_W = WORD_W / 2;
  localparam logic [REG_W-1:0] PTR_MASK = (REG_W'(1) << PTR_W) - REG_W'(1);

  logic [REG_W-1:0] ptrQ;
  logic [REG_W-1:0] ptrNext;
  logic [PTR_W-1:0] ptrCur;
  logic [PTR_W-1:0] effPtrQ;
  logic [PTR_W-1:0] effStart;
  logic [PTR_W-1:0] autoPtr;
  rdMode_e          modeQ;
  logic [7:0]       latchQ;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p, input logic down);
    logic [LOW_W-1:0] low;
    low = down ? (p[LOW_W-1:0] - LOW_W'(1)) : (p[LOW_W-1:0] + LOW_W'(1));
    return {p[PTR_W-1], low};
  endfunction

  assign ptrCur   = ptrQ[PTR_W-1:0];
  assign effStart = (rdMode_e'(rdMode) == MODE_PREINC) ? stepPtr(ptrCur, 1'b0) : ptrCur;

  always_comb begin
    case (modeQ)
      MODE_POSTINC: autoPtr = stepPtr(effPtrQ, 1'b0);
      MODE_POSTDEC: autoPtr = stepPtr(effPtrQ, 1'b1);
      default:      autoPtr = effPtrQ;
    endcase
  end

  always_comb begin
    ptrNext = ptrQ;
    if (strb.commit) ptrNext = REG_W'(autoPtr);
    if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_LOW:   ptrNext[7:0]   = regWrData;
        SEL_HIGH:  ptrNext[15:8]  = regWrData;
        SEL_UPPER: ptrNext[23:16] = regWrData;
        default:   ;
      endcase
    end
    ptrNext = ptrNext & PTR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ    <= '0;
      effPtrQ <= '0;
      modeQ   <= MODE_KEEP;
      latchQ  <= '0;
    end else begin
      ptrQ <= ptrNext;
      if (strb.capture) begin
        effPtrQ <= effStart;
        modeQ   <= rdMode_e'(rdMode);
      end
      if (strb.commit)
        latchQ <= effPtrQ[0] ? memData[WORD_W-1:HALF_W] : memData[HALF_W-1:0];
    end
  end

  assign ptrLow   = ptrQ[7:0];
  assign ptrHigh  = ptrQ[15:8];
  assign ptrUpper = ptrQ[23:16];
  assign latchOut = latchQ;
  assign memAddr  = effPtrQ[PTR_W-1:1];

  p_space_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !(regWrEn && regSel == 2'd2)) |=> (ptrQ[PTR_W-1] == $past(effPtrQ[PTR_W-1])));
  p_sel3_inert_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd3 && !strb.commit) |=> $stable(ptrQ));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWrData,
  output logic [7:0]        ptrLow,
  output logic [7:0]        ptrHigh,
  output logic [7:0]        ptrUpper,
  output logic [7:0]        latchOut,
  input  logic              rdStart,
  input  logic [1:0]        rdMode,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic [PTR_W-2:0]  memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData
);
  ctrlStrb_t strb;

  tblrd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .memValid(memValid),
    .strb(strb), .busy(busy), .done(done), .memReq(memReq)
  );

  tblrd_dpath #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdMode(rdMode),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memData(memData), .ptrLow(ptrLow), .ptrHigh(ptrHigh),
    .ptrUpper(ptrUpper), .latchOut(latchOut), .memAddr(memAddr)
  );

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> $stable(memAddr));
  p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    ptrUpper[7:6] == 2'b00);
endmodule

// File: tb/tblrd_unit_tb.sv
module tblrd_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  ptrLow, ptrHigh, ptrUpper, latchOut;
  logic        rdStart = 1'b0;
  logic [1:0]  rdMode = '0;
  logic        busy, done, memReq;
  logic [20:0] memAddr;
  logic        memValid = 1'b0;
  logic [15:0] memData = '0;

  int errors = 0;
  int total = 0;
  bit finished = 1'b0;
  logic [21:0] modelPtr = '0;

  always #10 clk = ~clk;

  tblrd_unit u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .ptrLow(ptrLow), .ptrHigh(ptrHigh), .ptrUpper(ptrUpper), .latchOut(latchOut),
    .rdStart(rdStart), .rdMode(rdMode), .busy(busy), .done(done), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] curPtr();
    return {ptrUpper[5:0], ptrHigh, ptrLow};
  endfunction

  function automatic logic [21:0] stepB(input logic [21:0] p, input bit down);
    logic [20:0] l;
    l = down ? p[20:0] - 21'd1 : p[20:0] + 21'd1;
    return {p[21], l};
  endfunction

  function automatic logic [15:0] memWord(input logic [20:0] a);
    return {(~a[7:0]) ^ a[15:8], a[7:0] ^ 8'h3C};
  endfunction

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setPtr(input logic [21:0] p);
    wrReg(2'd0, p[7:0]);
    wrReg(2'd1, p[15:8]);
    wrReg(2'd2, {2'b00, p[21:16]});
    modelPtr = p;
    chk("R2", "pointer load", 32'(curPtr()), 32'(p));
  endtask

  // collide: software writes regSel=0 with collVal on the completing edge
  task automatic doRead(input string req, input logic [1:0] mode, input int lat,
                        input bit extraStart, input bit collide, input logic [7:0] collVal);
    logic [21:0] eff, fin;
    logic [15:0] word;
    logic [7:0]  expByte;
    eff = (mode == 2'b11) ? stepB(modelPtr, 1'b0) : modelPtr;
    case (mode)
      2'b01:   fin = stepB(modelPtr, 1'b0);
      2'b10:   fin = stepB(modelPtr, 1'b1);
      default: fin = eff;
    endcase
    if (collide) fin[7:0] = collVal;
    word = memWord(eff[21:1]);
    expByte = eff[0] ? word[15:8] : word[7:0];
    @(negedge clk);
    rdStart = 1'b1; rdMode = mode;
    @(negedge clk);
    rdStart = 1'b0;
    chk("R9", "busy after start", 32'(busy), 1);
    chk("R9", "memReq after start", 32'(memReq), 1);
    chk("R7", "word address", 32'(memAddr), 32'(eff[21:1]));
    for (int i = 0; i < lat; i++) begin
      if (extraStart && i == 0) begin
        rdStart = 1'b1; rdMode = ~mode;
      end
      @(negedge clk);
      rdStart = 1'b0;
      chk("R9", "memReq held", 32'(memReq), 1);
      chk("R10", "address steady", 32'(memAddr), 32'(eff[21:1]));
    end
    memValid = 1'b1; memData = word;
    if (collide) begin
      regWrEn = 1'b1; regSel = 2'd0; regWrData = collVal;
    end
    @(negedge clk);
    memValid = 1'b0; regWrEn = 1'b0;
    chk("R9", "done pulse", 32'(done), 1);
    chk("R9", "busy cleared", 32'(busy), 0);
    chk(req, "latch byte", 32'(latchOut), 32'(expByte));
    chk(collide ? "R11" : req, "pointer after read", 32'(curPtr()), 32'(fin));
    @(negedge clk);
    chk("R9", "done single cycle", 32'(done), 0);
    chk(req, "pointer held", 32'(curPtr()), 32'(fin));
    modelPtr = fin;
  endtask

  task automatic testReset();
    chk("R1", "ptrLow", 32'(ptrLow), 0);
    chk("R1", "ptrHigh", 32'(ptrHigh), 0);
    chk("R1", "ptrUpper", 32'(ptrUpper), 0);
    chk("R1", "latch", 32'(latchOut), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "memReq", 32'(memReq), 0);
  endtask

  task automatic testRegs();
    setPtr(22'h12_3456);
    wrReg(2'd3, 8'hEE);
    chk("R2", "code 3 inert", 32'(curPtr()), 32'h12_3456);
    wrReg(2'd2, 8'hFF);
    chk("R2", "upper top bits zero", 32'(ptrUpper), 32'h3F);
    modelPtr = 22'h3F_3456;
  endtask

  task automatic testModes();
    setPtr(22'h00_1234);
    doRead("R3", 2'b00, 1, 1'b0, 1'b0, 8'h00);
    doRead("R4", 2'b01, 0, 1'b0, 1'b0, 8'h00);
    doRead("R7", 2'b01, 2, 1'b0, 1'b0, 8'h00);
    doRead("R5", 2'b10, 3, 1'b0, 1'b0, 8'h00);
    doRead("R6", 2'b11, 1, 1'b0, 1'b0, 8'h00);
    doRead("R6", 2'b11, 0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic testWrap();
    setPtr(22'h3F_FFFF);
    doRead("R8", 2'b01, 1, 1'b0, 1'b0, 8'h00);
    chk("R8", "inc wrap keeps bit21", 32'(curPtr()), 32'h20_0000);
    doRead("R8", 2'b10, 2, 1'b0, 1'b0, 8'h00);
    chk("R8", "dec wrap keeps bit21", 32'(curPtr()), 32'h3F_FFFF);
    setPtr(22'h1F_FFFF);
    doRead("R8", 2'b11, 1, 1'b0, 1'b0, 8'h00);
    chk("R8", "pre-inc wrap in main space", 32'(curPtr()), 32'h00_0000);
  endtask

  task automatic testBusyIgnore();
    setPtr(22'h05_0A0B);
    doRead("R10", 2'b01, 4, 1'b1, 1'b0, 8'h00);
    chk("R10", "no second request", 32'(busy), 0);
  endtask

  task automatic testCollision();
    setPtr(22'h00_00FF);
    doRead("R11", 2'b01, 2, 1'b0, 1'b1, 8'h55);
    chk("R11", "high byte from auto update", 32'(ptrHigh), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testModes();
    testWrap();
    testBusyIgnore();
    testCollision();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; total++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule